// File: doc/BRIEF.md
# PLL Retune Sequencer

This block changes a PLL's multiplier without ever driving a half-configured clock downstream. On a request it captures a new multiplier word and the current contents of the PLL control register. It then drives a single-cycle register write port in a fixed order. First it writes a power-down control word. Then it writes the multiplier word and a divider word that sets the pre-divider and post-divider to one. Next it writes a power-up word with the output still gated, and polls the PLL lock flag.

When lock is seen, a last control write opens the output gate and the block pulses `done`. If the lock flag is still low after a bounded number of polls, spaced a fixed number of cycles apart, the block pulses `lock_fail` and leaves the output gate closed. The control register is handled as a read-modify-write. Control bits outside the five it owns keep the value that was sampled when the request was accepted.

Top module: `pll_retune_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `lock_fail` and `wr_en` are all 0.
- R2: The first write of a sequence goes to address 0 (control), one cycle after acceptance. Its data is the sampled control value with bit 0 (power-down) set, bits 1 to 4 (bypass, direct-in, direct-out, clock enable) cleared, and bits 31:5 unchanged.
- R3: The second write goes to address 1 (multiplier) and carries the requested multiplier word, zero-extended to 32 bits.
- R4: The third write goes to address 2 (divider) with data 0x00302062.
- R5: The fourth write goes to address 0 with bits 4:0 all zero and bits 31:5 as in R2.
- R6: After the R5 write, bit 0 of `stat_rd` is sampled first on the next cycle and then every POLL_GAP cycles. At most MAX_POLLS samples are taken.
- R7: If a sample finds lock, the next cycle writes address 0 with bit 4 set, bits 3:0 zero and bits 31:5 as in R2. `done` is high for exactly the following cycle.
- R8: If no sample finds lock, `lock_fail` is high for one cycle right after the last sample, no clock-enable write is issued, and `done` stays low.
- R9: `busy` is high from the cycle after acceptance until the cycle that carries `done` or `lock_fail`, inclusive. A request raised while `busy` is high is ignored: it causes no extra write and does not change the words written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Retune request, taken when idle |
| req_mult | input | MW | New multiplier word |
| ctrl_rd | input | 32 | Current PLL control register value |
| stat_rd | input | 32 | PLL status register, bit 0 = locked |
| wr_en | output | 1 | Register write strobe, one cycle per write |
| wr_addr | output | 2 | Write target: 0 control, 1 multiplier, 2 divider |
| wr_data | output | 32 | Write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse: PLL locked and output enabled |
| lock_fail | output | 1 | One-cycle pulse: lock not seen within the poll budget |

## Verification
Each wrong state step shows at the write port as a misordered address or a wrong control word. It appears within one cycle of the step that went astray. A wrong poll counter shows as `done` or `lock_fail` arriving a whole POLL_GAP early or late. The bench therefore times both pulses to the exact cycle, and places the lock delay exactly at the last poll and one cycle past it. A corrupted capture of the control value shows in bits 31:5 of every control write.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    REG_CTRL  = 2'd0,
    REG_MDIV  = 2'd1,
    REG_NPDIV = 2'd2
  } reg_sel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PDN, ST_MULT, ST_DIVS, ST_PUP, ST_WAIT, ST_OPEN, ST_OK, ST_ERR
  } seq_state_e;

  localparam logic [31:0] DIVS_UNITY = 32'h0030_2062;
  localparam int          BIT_PD     = 0;
  localparam int          BIT_CLKEN  = 4;
  localparam logic [31:0] OWNED_MASK = 32'h0000_001F;

  function automatic logic [31:0] word_powerdown(input logic [31:0] c);
    logic [31:0] w;
    w = c & ~OWNED_MASK;
    w[BIT_PD] = 1'b1;
    return w;
  endfunction

  function automatic logic [31:0] word_powerup(input logic [31:0] c);
    return c & ~OWNED_MASK;
  endfunction

  function automatic logic [31:0] word_open(input logic [31:0] c);
    logic [31:0] w;
    w = c & ~OWNED_MASK;
    w[BIT_CLKEN] = 1'b1;
    return w;
  endfunction

endpackage

// File: rtl/pll_poll_timer.sv
module pll_poll_timer #(
  parameter int POLL_GAP  = 100,
  parameter int MAX_POLLS = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic poll_fire,
  output logic last_poll
);
  localparam int GW = $clog2(POLL_GAP + 1);
  localparam int PW = $clog2(MAX_POLLS + 1);

  logic [GW-1:0] gap_cnt;
  logic [PW-1:0] poll_cnt;

  assign poll_fire = run && (gap_cnt == '0);
  assign last_poll = poll_fire && (poll_cnt == PW'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      gap_cnt  <= '0;
      poll_cnt <= '0;
    end else if (run) begin
      if (gap_cnt == '0) begin
        gap_cnt  <= GW'(POLL_GAP - 1);
        poll_cnt <= poll_cnt + 1'b1;
      end else begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end

  assert_poll_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_cnt <= PW'(MAX_POLLS));

  assert_poll_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_fire && run && POLL_GAP > 1) |=> !poll_fire);

endmodule

// File: rtl/pll_ctrl_shaper.sv
module pll_ctrl_shaper
  import pll_seq_pkg::*;
(
  input  logic [31:0] base,
  output logic [31:0] pd_word,
  output logic [31:0] pu_word,
  output logic [31:0] en_word
);
  always_comb begin
    pd_word = word_powerdown(base);
    pu_word = word_powerup(base);
    en_word = word_open(base);
  end
endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_seq_pkg::*;
#(
  parameter int MW        = 17,
  parameter int POLL_GAP  = 100,
  parameter int MAX_POLLS = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [MW-1:0] req_mult,
  input  logic [31:0]   ctrl_rd,
  input  logic [31:0]   stat_rd,
  output logic          wr_en,
  output logic [1:0]    wr_addr,
  output logic [31:0]   wr_data,
  output logic          busy,
  output logic          done,
  output logic          lock_fail
);
  seq_state_e  state, state_nx;
  logic [31:0] ctrl_q;
  logic [MW-1:0] mult_q;
  logic [31:0] pd_word, pu_word, en_word;
  logic        poll_fire, last_poll;
  logic        accept, lock_seen;
  reg_sel_e    sel;

  assign accept    = (state == ST_IDLE) && req_valid;
  assign lock_seen = poll_fire && stat_rd[0];

  pll_ctrl_shaper u_shape (
    .base   (ctrl_q),
    .pd_word(pd_word),
    .pu_word(pu_word),
    .en_word(en_word)
  );

  pll_poll_timer #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (state == ST_PUP),
    .run      (state == ST_WAIT),
    .poll_fire(poll_fire),
    .last_poll(last_poll)
  );

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE: if (accept) state_nx = ST_PDN;
      ST_PDN:  state_nx = ST_MULT;
      ST_MULT: state_nx = ST_DIVS;
      ST_DIVS: state_nx = ST_PUP;
      ST_PUP:  state_nx = ST_WAIT;
      ST_WAIT: if (lock_seen) state_nx = ST_OPEN;
               else if (last_poll) state_nx = ST_ERR;
      ST_OPEN: state_nx = ST_OK;
      ST_OK:   state_nx = ST_IDLE;
      ST_ERR:  state_nx = ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      ctrl_q <= '0;
      mult_q <= '0;
    end else begin
      state <= state_nx;
      if (accept) begin
        ctrl_q <= ctrl_rd;
        mult_q <= req_mult;
      end
    end
  end

  always_comb begin
    wr_en   = 1'b0;
    sel     = REG_CTRL;
    wr_data = '0;
    unique case (state)
      ST_PDN:  begin wr_en = 1'b1; sel = REG_CTRL;  wr_data = pd_word; end
      ST_MULT: begin wr_en = 1'b1; sel = REG_MDIV;  wr_data = 32'(mult_q); end
      ST_DIVS: begin wr_en = 1'b1; sel = REG_NPDIV; wr_data = DIVS_UNITY; end
      ST_PUP:  begin wr_en = 1'b1; sel = REG_CTRL;  wr_data = pu_word; end
      ST_OPEN: begin wr_en = 1'b1; sel = REG_CTRL;  wr_data = en_word; end
      default: ;
    endcase
  end

  assign wr_addr   = sel;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_OK);
  assign lock_fail = (state == ST_ERR);

  assert_write_needs_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy);

  assert_mult_after_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1) |-> $past(wr_en && wr_addr == 2'd0 && wr_data[0]));

  assert_divs_unity_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd2) |-> (wr_data == 32'h0030_2062));

  assert_open_after_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && wr_data[4]) |-> $past(poll_fire && stat_rd[0]));

  assert_done_after_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_data[4]));

  assert_outcome_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && lock_fail));

  assert_ends_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || lock_fail) |=> !busy);

endmodule

// File: tb/test_pll_retune_seq.sv
module test_pll_retune_seq;
  localparam int MW = 17;
  localparam int G  = 4;
  localparam int M  = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [MW-1:0] req_mult = '0;
  logic [31:0]   ctrl_rd = '0;
  logic [31:0]   stat_rd;
  logic          wr_en, busy, done, lock_fail;
  logic [1:0]    wr_addr;
  logic [31:0]   wr_data;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int lock_delay = 0;
  logic armed = 1'b0;
  int   lcnt = 0;

  int          nwr;
  logic [1:0]  la [0:15];
  logic [31:0] ld [0:15];
  int          busy_bad;

  always #4 clk = ~clk;

  pll_retune_seq #(.MW(MW), .POLL_GAP(G), .MAX_POLLS(M)) i_pll_retune_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mult(req_mult),
    .ctrl_rd(ctrl_rd), .stat_rd(stat_rd), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .lock_fail(lock_fail)
  );

  // PLL stand-in: lock rises lock_delay cycles after the power-up write
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (wr_en && wr_addr == 2'd0 && wr_data[0]) armed <= 1'b0;
    else if (wr_en && wr_addr == 2'd0 && wr_data[4:0] == 5'd0) begin
      armed <= 1'b1; lcnt <= 0;
    end else if (armed && lcnt < 100000) lcnt <= lcnt + 1;
  end
  assign stat_rd = {31'd0, armed && (lcnt >= lock_delay)};

  always @(negedge clk) begin
    if (rst_n && wr_en && nwr < 16) begin
      la[nwr] = wr_addr; ld[nwr] = wr_data; nwr = nwr + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one request; returns the cycle index of the first busy cycle and the end cycle
  task automatic run_seq(input logic [MW-1:0] m, input logic [31:0] c, input int d,
                         input bit poke, output int p, output int endc,
                         output bit ok, output bit fl);
    nwr = 0; busy_bad = 0; lock_delay = d;
    @(negedge clk);
    req_valid = 1'b1; req_mult = m; ctrl_rd = c;
    @(negedge clk);
    p = cyc; req_valid = 1'b0;
    ctrl_rd = ~c;
    ok = 0; fl = 0; endc = -1;
    for (int k = 0; k < 2000; k++) begin
      if (!busy) busy_bad++;
      if (poke && k == 2) begin req_valid = 1'b1; req_mult = ~m; end
      if (poke && k == 3) req_valid = 1'b0;
      if (done || lock_fail) begin ok = done; fl = lock_fail; endc = cyc; break; end
      @(negedge clk);
    end
    @(negedge clk);
    check("R9 idle after end", {31'd0, busy}, 32'd0);
  endtask

  function automatic logic [31:0] upper(input logic [31:0] c);
    return {c[31:5], 5'd0};
  endfunction

  task automatic check_prefix(input logic [MW-1:0] m, input logic [31:0] c);
    check("R2 addr", {30'd0, la[0]}, 32'd0);
    check("R2 data", ld[0], upper(c) + 32'd1);
    check("R3 addr", {30'd0, la[1]}, 32'd1);
    check("R3 data", ld[1], {{(32-MW){1'b0}}, m});
    check("R4 addr", {30'd0, la[2]}, 32'd2);
    check("R4 data", ld[2], 32'h0030_2062);
    check("R5 addr", {30'd0, la[3]}, 32'd0);
    check("R5 data", ld[3], upper(c));
  endtask

  task automatic t_lock(input logic [MW-1:0] m, input logic [31:0] c, input int d,
                        input bit poke);
    int p, e, j; bit ok, fl;
    run_seq(m, c, d, poke, p, e, ok, fl);
    j = (d + G - 1) / G;
    check("R7 done", {31'd0, ok}, 32'd1);
    check("R7 no fail", {31'd0, fl}, 32'd0);
    check("R6 done cycle", e, p + 6 + j * G);
    check("R9 write count", nwr, 5);
    check("R9 busy held", busy_bad, 0);
    check_prefix(m, c);
    check("R7 addr", {30'd0, la[4]}, 32'd0);
    check("R7 data", ld[4], upper(c) | 32'h10);
  endtask

  task automatic t_fail(input logic [MW-1:0] m, input logic [31:0] c, input int d);
    int p, e; bit ok, fl;
    run_seq(m, c, d, 1'b0, p, e, ok, fl);
    check("R8 fail", {31'd0, fl}, 32'd1);
    check("R8 no done", {31'd0, ok}, 32'd0);
    check("R8 fail cycle", e, p + 5 + (M - 1) * G);
    check("R8 write count", nwr, 4);
    check_prefix(m, c);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 lock_fail", {31'd0, lock_fail}, 32'd0);
    check("R1 wr_en", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {31'd0, busy | wr_en}, 32'd0);
    t_lock(17'h1ABCD, 32'hABCD_001F, 0, 1'b0);
    t_lock(17'h00042, 32'h1234_5660, 5, 1'b0);
    t_lock(17'h10003, 32'hFFFF_FFE0, (M - 1) * G, 1'b0);
    t_fail(17'h18003, 32'h0F0F_0F0A, (M - 1) * G + 1);
    t_fail(17'h00001, 32'h8000_0015, 1000000);
    t_lock(17'h0BEEF, 32'h5A5A_5A55, 9, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule